// File: doc/BRIEF.md
# Lane-Restricted Byte Shuffle Unit

This unit is a SIMD execution stage that rearranges the bytes of a 256-bit vector. Each byte of a control vector picks which source byte lands in the same position of the result, or forces that result byte to zero. The choice of source vector, how many index bits are used, and what happens to the upper half of the result all depend on a 2-bit mode. In the widest mode, the vector is handled as two independent 128-bit lanes, and an index can never reach across a lane boundary.

The unit sits after decode and operand fetch. It receives the data vector, the control vector, the prior destination value, the mode, and a flag that marks a control vector read from memory together with its address. Operands are captured on a cycle where `inValid` is high. The result, the fault flag and `outValid` appear on the next clock. A control vector from memory that is not 16-byte aligned, used in either 128-bit mode, raises the fault and leaves the result register unchanged. The control vector is only read, never written.

Top module: `shuf_unit`

## Requirements
- R1: When bit 7 of a control byte is 1, the matching result byte is 0x00, whatever that byte's index bits hold.
- R2: Mode 2'b00 (narrow) permutes the low 8 bytes of `priorDst`, taking the index from control bits [2:0]. Result bits 255:64 equal `priorDst` bits 255:64.
- R3: Control bits [6:4] have no effect in the 128-bit and 256-bit modes, and bits [6:3] have none in the narrow mode. The 128-bit modes use a 4-bit index from bits [3:0] that selects among the 16 low source bytes.
- R4: Mode 2'b11 (dual lane) fills result bytes 0..15 only from data and control bits 127:0. It fills bytes 16..31 only from bits 255:128, using a 4-bit index relative to byte 16.
- R5: Mode 2'b01 (in-place 128) permutes the low 16 bytes of `priorDst`. Result bits 255:128 equal `priorDst` bits 255:128.
- R6: Mode 2'b10 (split 128) permutes the low 16 bytes of `dataVec`. Result bits 255:128 are zero.
- R7: When `memOperand` is 1, the mode is 2'b01 or 2'b10, and `memAddr[3:0]` is not zero, `fault` is 1 with `outValid` on the next cycle, and `resultVec` keeps its previous value.
- R8: `fault` stays 0 for aligned memory operands, for register operands, and for any address in modes 2'b00 and 2'b11.
- R9: `outValid` is 1 exactly in the cycle after a cycle with `inValid` high. `resultVec` changes only in that cycle, and otherwise holds.
- R10: A synchronous active-high `rst` clears `outValid`, `fault` and `resultVec` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands present this cycle |
| modeSel | input | 2 | 00 narrow, 01 in-place 128, 10 split 128, 11 dual lane |
| dataVec | input | 256 | Separate data source (modes 10 and 11) |
| ctrlVec | input | 256 | Per-byte zero flag and index |
| priorDst | input | 256 | Prior destination value (source in modes 00 and 01, pass-through) |
| memOperand | input | 1 | Control vector was read from memory |
| memAddr | input | 64 | Address of the memory control vector |
| outValid | output | 1 | Result and fault valid |
| fault | output | 1 | Misaligned memory control in a 128-bit mode |
| resultVec | output | 256 | Registered shuffle result |

## Verification
The assertions assume that `modeSel`, `memOperand` and `memAddr` are meaningful only while `inValid` is high. They also assume that `rst` is held for at least one clock before the first operation. The stimulus drives every input on the falling edge and returns `inValid` to zero between bursts. Addresses are random across all four modes, so misaligned memory operands also reach the narrow and dual-lane modes, where no fault may appear.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

  typedef enum logic [1:0] {
    MODE_NARROW  = 2'b00,
    MODE_INPLACE = 2'b01,
    MODE_SPLIT   = 2'b10,
    MODE_DUAL    = 2'b11
  } shufMode_e;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic loadRes;    // capture a new result this cycle
    logic selDst;     // permute priorDst instead of dataVec
    logic narrowIdx;  // short index, 8-byte window
    logic dualLane;   // upper lane shuffled on its own
    logic clearUpper; // upper lanes forced to zero
  } shufStrobe_t;

endpackage

// File: rtl/shuf_ctrl.sv
module shuf_ctrl
  import shuf_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        modeSel,
  input  logic              memOperand,
  input  logic [ADDR_W-1:0] memAddr,
  output shufStrobe_t       strobe,
  output logic              outValid,
  output logic              fault
);

  shufMode_e mode;
  logic      misaligned;

  assign mode = shufMode_e'(modeSel);

  assign misaligned = memOperand
                    && (mode == MODE_INPLACE || mode == MODE_SPLIT)
                    && (memAddr[ALIGN_BITS-1:0] != '0);

  always_comb begin
    strobe.loadRes    = inValid && !misaligned;
    strobe.selDst     = (mode == MODE_NARROW) || (mode == MODE_INPLACE);
    strobe.narrowIdx  = (mode == MODE_NARROW);
    strobe.dualLane   = (mode == MODE_DUAL);
    strobe.clearUpper = (mode == MODE_SPLIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      fault    <= 1'b0;
    end else begin
      outValid <= inValid;
      fault    <= inValid && misaligned;
    end
  end

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!outValid && !fault));

  p_valid_next_r9: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  p_fault_with_valid_r7: assert property (@(posedge clk) disable iff (rst)
    fault |-> outValid);

  p_no_fault_dual_r8: assert property (@(posedge clk) disable iff (rst)
    (inValid && modeSel == 2'b11) |=> !fault);

  p_no_fault_reg_r8: assert property (@(posedge clk) disable iff (rst)
    (inValid && !memOperand) |=> !fault);

endmodule

// File: rtl/shuf_datapath.sv
module shuf_datapath
  import shuf_pkg::*;
#(
  parameter int LANE_BYTES = 16,
  parameter int LANES      = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  shufStrobe_t                   strobe,
  input  logic [LANES*LANE_BYTES*8-1:0] dataVec,
  input  logic [LANES*LANE_BYTES*8-1:0] ctrlVec,
  input  logic [LANES*LANE_BYTES*8-1:0] priorDst,
  output logic [LANES*LANE_BYTES*8-1:0] resultVec
);

  localparam int BYTES  = LANES * LANE_BYTES;
  localparam int DW     = BYTES * 8;
  localparam int LW     = LANE_BYTES * 8;
  localparam int IDX_W  = $clog2(LANE_BYTES);
  localparam int HALF   = LANE_BYTES / 2;

  logic [DW-1:0] srcSel;
  wire  [DW-1:0] nextVec;

  assign srcSel = strobe.selDst ? priorDst : dataVec;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar j = 0; j < LANE_BYTES; j++) begin : g_byte
      localparam int K    = l * LANE_BYTES + j;
      localparam int BASE = l * LANE_BYTES;
      logic [7:0]       cb;
      logic [IDX_W-1:0] idx;
      logic [7:0]       picked;

      assign cb     = ctrlVec[K*8 +: 8];
      assign idx    = strobe.narrowIdx ? {1'b0, cb[IDX_W-2:0]} : cb[IDX_W-1:0];
      assign picked = cb[7] ? 8'h00 : srcSel[(BASE + 32'(idx))*8 +: 8];

      if (l == 0) begin : g_low
        if (j >= HALF) begin : g_hi_half
          assign nextVec[K*8 +: 8] = strobe.narrowIdx ? priorDst[K*8 +: 8] : picked;
        end else begin : g_lo_half
          assign nextVec[K*8 +: 8] = picked;
        end
      end else begin : g_up
        assign nextVec[K*8 +: 8] = strobe.dualLane   ? picked :
                                   strobe.clearUpper ? 8'h00  :
                                                       priorDst[K*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 resultVec <= '0;
    else if (strobe.loadRes) resultVec <= nextVec;
  end

  p_hold_no_load_r7: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadRes |=> $stable(resultVec));

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadRes && strobe.clearUpper) |=> (resultVec[DW-1:LW] == '0));

  p_msb_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadRes && ctrlVec[7]) |=> (resultVec[7:0] == 8'h00));

  p_narrow_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadRes && strobe.narrowIdx) |=>
      (resultVec[DW-1:HALF*8] == $past(priorDst[DW-1:HALF*8])));

endmodule

// File: rtl/shuf_unit.sv
module shuf_unit
  import shuf_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LANE_BYTES = 16,
  parameter int LANES      = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          inValid,
  input  logic [1:0]                    modeSel,
  input  logic [LANES*LANE_BYTES*8-1:0] dataVec,
  input  logic [LANES*LANE_BYTES*8-1:0] ctrlVec,
  input  logic [LANES*LANE_BYTES*8-1:0] priorDst,
  input  logic                          memOperand,
  input  logic [ADDR_W-1:0]             memAddr,
  output logic                          outValid,
  output logic                          fault,
  output logic [LANES*LANE_BYTES*8-1:0] resultVec
);

  localparam int ALIGN_BITS = $clog2(LANE_BYTES);

  shufStrobe_t strobe;

  shuf_ctrl #(
    .ADDR_W     (ADDR_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .modeSel    (modeSel),
    .memOperand (memOperand),
    .memAddr    (memAddr),
    .strobe     (strobe),
    .outValid   (outValid),
    .fault      (fault)
  );

  shuf_datapath #(
    .LANE_BYTES (LANE_BYTES),
    .LANES      (LANES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .dataVec   (dataVec),
    .ctrlVec   (ctrlVec),
    .priorDst  (priorDst),
    .resultVec (resultVec)
  );

endmodule

// File: tb/sim_shuf_unit.sv
`timescale 1ns/1ps
module sim_shuf_unit;

  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [1:0]   modeSel;
  logic [255:0] dataVec, ctrlVec, priorDst;
  logic         memOperand;
  logic [63:0]  memAddr;
  logic         outValid, fault;
  logic [255:0] resultVec;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [255:0] expRes;

  always #4 clk = ~clk;

  shuf_unit u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .modeSel(modeSel),
    .dataVec(dataVec), .ctrlVec(ctrlVec), .priorDst(priorDst),
    .memOperand(memOperand), .memAddr(memAddr),
    .outValid(outValid), .fault(fault), .resultVec(resultVec)
  );

  function automatic logic [255:0] rand256();
    logic [255:0] v;
    for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [255:0] refModel(logic [1:0] m, logic [255:0] d,
                                            logic [255:0] c, logic [255:0] p);
    logic [255:0] r;
    for (int i = 0; i < 32; i++) begin
      logic [7:0] cb;
      int idx;
      cb = c[i*8 +: 8];
      r[i*8 +: 8] = p[i*8 +: 8];
      case (m)
        2'b00: if (i < 8) begin
          idx = cb[2:0];
          r[i*8 +: 8] = cb[7] ? 8'h00 : p[idx*8 +: 8];
        end
        2'b01: if (i < 16) begin
          idx = cb[3:0];
          r[i*8 +: 8] = cb[7] ? 8'h00 : p[idx*8 +: 8];
        end
        2'b10: begin
          idx = cb[3:0];
          if (i < 16) r[i*8 +: 8] = cb[7] ? 8'h00 : d[idx*8 +: 8];
          else        r[i*8 +: 8] = 8'h00;
        end
        default: begin
          idx = cb[3:0] + ((i >= 16) ? 16 : 0);
          r[i*8 +: 8] = cb[7] ? 8'h00 : d[idx*8 +: 8];
        end
      endcase
    end
    return r;
  endfunction

  task automatic check1(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(logic [1:0] m, logic [255:0] d, logic [255:0] c,
                       logic [255:0] p, logic mop, logic [63:0] a, string tag);
    logic expF;
    expF = mop && (m == 2'b01 || m == 2'b10) && (a[3:0] != 4'h0);
    if (!expF) expRes = refModel(m, d, c, p);
    modeSel = m; dataVec = d; ctrlVec = c; priorDst = p;
    memOperand = mop; memAddr = a; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check1(outValid == 1'b1, {tag, " R9 valid"}, 256'(outValid), 256'd1);
    check1(fault == expF, {tag, expF ? " R7 fault" : " R8 fault"}, 256'(fault), 256'(expF));
    check1(resultVec == expRes, {tag, " result"}, resultVec, expRes);
  endtask

  task automatic idleCycle();
    @(negedge clk);
    check1(outValid == 1'b0, "R9 idle valid", 256'(outValid), 256'd0);
    check1(resultVec == expRes, "R9 idle hold", resultVec, expRes);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] d, p, c, cIdent, cRev, cAllMsb, cHi;
    rst = 1'b1; inValid = 1'b0; modeSel = 2'b00; dataVec = '0; ctrlVec = '0;
    priorDst = '0; memOperand = 1'b0; memAddr = '0;
    repeat (3) @(negedge clk);
    check1(outValid == 1'b0 && fault == 1'b0, "R10 reset flags",
           256'({outValid, fault}), 256'd0);
    check1(resultVec == '0, "R10 reset result", resultVec, 256'd0);
    rst = 1'b0;
    expRes = '0;
    idleCycle();

    for (int i = 0; i < 32; i++) begin
      cIdent[i*8 +: 8] = 8'(i % 16);
      cRev[i*8 +: 8]   = 8'(15 - (i % 16));
      cAllMsb[i*8 +: 8] = 8'h80 | 8'(i);
    end
    d = rand256(); p = rand256();

    for (int m = 0; m < 4; m++) begin
      runOp(2'(m), d, '0,      p, 1'b0, 64'h0, "R2 R3 R5 R6 all-zero index");
      runOp(2'(m), d, cAllMsb, p, 1'b0, 64'h0, "R1 all msb");
      runOp(2'(m), d, cIdent,  p, 1'b0, 64'h0, "R4 identity");
      runOp(2'(m), d, cRev,    p, 1'b0, 64'h0, "R4 reversal");
      cHi = cRev | {32{8'h70}};
      runOp(2'(m), d, cHi,     p, 1'b0, 64'h0, "R3 ignored bits");
    end
    // narrow mode: bit 3 also ignored
    runOp(2'b00, d, cRev | {32{8'h78}}, p, 1'b0, 64'h0, "R3 narrow bit3");
    idleCycle();

    // misaligned memory control in 128-bit modes: fault, result held
    runOp(2'b10, d, cRev, p, 1'b0, 64'h0, "R6 setup");
    runOp(2'b01, rand256(), rand256(), rand256(), 1'b1, 64'h1004, "R7 inplace misaligned");
    runOp(2'b10, rand256(), rand256(), rand256(), 1'b1, 64'h000f, "R7 split misaligned");
    idleCycle();
    runOp(2'b10, d, cIdent, p, 1'b1, 64'h2000, "R8 split aligned");
    runOp(2'b11, d, cRev,   p, 1'b1, 64'h2003, "R8 dual misaligned");
    runOp(2'b00, d, cRev,   p, 1'b1, 64'h2009, "R8 narrow misaligned");

    // dual lane: changing low-lane data must not touch high lane
    c = rand256();
    runOp(2'b11, d, c, p, 1'b0, 64'h0, "R4 lane A");
    runOp(2'b11, {d[255:128], ~d[127:0]}, c, p, 1'b0, 64'h0, "R4 lane B");

    for (int n = 0; n < 300; n++) begin
      logic [63:0] a;
      a = {$urandom, $urandom};
      runOp(2'($urandom), rand256(), rand256(), rand256(), 1'($urandom), a,
            "R1 R2 R4 R5 R6 R7 random");
      if (($urandom % 4) == 0) idleCycle();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule